// File: doc/BRIEF.md
# Sleep-Clock Watchdog Timer

This block is a down-counting watchdog that runs on the slow 32 kHz sleep clock. Software programs a timeout value, and the counter steps down by one each sleep-clock period. If software never reloads it in time, the count runs out. The block then raises a one-cycle reset request and starts again from the programmed value. At 21 bits and about 30.5 µs per step, the longest timeout is roughly 64 seconds.

Software reaches the block through a small write port with two targets. The first is the timeout value. The second is a control word that can freeze the counter or ask for an immediate system reset. The running count, the programmed timeout and the freeze state are visible at all times as outputs.

A low-power input stops counting while the system sleeps. A wake pulse forces the counter back to the programmed timeout. Timeout writes are rate-limited: a write that lands too soon after the previous accepted one is dropped.

Top module: `sleep_wdt`

## Requirements
- R1: After reset, `cur_count` and `init_value` both equal the normalised `RST_INIT`, `stop_state` is 0, and `expire_rst` and `soft_rst` are 0.
- R2: In each clock cycle where `stop_state` is 0, `low_power` is 0, `wake` is 0 and `cur_count` is above 1, the count decreases by exactly one at the next edge.
- R3: A control write (`reg_sel`=1) loads `stop_state` from `reg_wdata[0]`. While `stop_state` is 1 the count holds its value. After the bit is cleared, counting resumes from the held value.
- R4: While `low_power` is 1 and `wake` is 0, the count does not change.
- R5: A cycle with `wake`=1 loads `cur_count` from `init_value` at the next edge. This takes priority over stop, low power and expiry.
- R6: The timeout runs for `init_value` steps. After the reload from value N, the N-th running edge pulses `expire_rst` for one cycle and reloads `init_value`. `cur_count` never shows 0.
- R7: A timeout write (`reg_sel`=0) is accepted only if at least `WR_GAP` (default 2) cycles have passed since the last accepted timeout write. A write that comes earlier leaves `init_value` unchanged.
- R8: An accepted timeout write of 0 stores 1.
- R9: A control write with `reg_wdata[1]`=1 produces a one-cycle `soft_rst` pulse at the next edge. Writing 0 to that bit produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz sleep clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_sel | input | 1 | Write target: 0 timeout value, 1 control word |
| reg_wdata | input | CNT_W | Write data; control uses bit 0 (stop) and bit 1 (soft reset) |
| low_power | input | 1 | System is in low-power mode |
| wake | input | 1 | Wake-up pulse, forces a reload |
| init_value | output | CNT_W | Programmed timeout value |
| cur_count | output | CNT_W | Current count |
| stop_state | output | 1 | Counter frozen by software |
| expire_rst | output | 1 | One-cycle reset request on timeout |
| soft_rst | output | 1 | One-cycle software reset request |

## Verification
The bench builds the block with `CNT_W`=5, `RST_INIT`=5 and `WR_GAP`=2. This makes every legal timeout from 1 to 31 small enough to sweep in full, with the exact expiry cycle and the count after each step predicted arithmetically. The small width also makes the reload value of 1 reachable, where expiry fires on every running cycle. Write spacing is exercised one cycle too early and then exactly on the limit.

// File: rtl/sleep_wdt.sv
module sleep_wdt #(
  parameter int CNT_W    = 21,
  parameter int WR_GAP   = 2,
  parameter int RST_INIT = 2097151
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             low_power,
  input  logic             wake,
  output logic [CNT_W-1:0] init_value,
  output logic [CNT_W-1:0] cur_count,
  output logic             stop_state,
  output logic             expire_rst,
  output logic             soft_rst
);
  localparam int GAP_W = $clog2(WR_GAP + 1);
  localparam logic [CNT_W-1:0] RST_LOAD = (RST_INIT == 0) ? CNT_W'(1) : CNT_W'(RST_INIT);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(WR_GAP);

  logic [GAP_W-1:0] since_wr;
  logic [CNT_W-1:0] init_q, cnt_q;
  logic             stop_q, expire_q, soft_q;

  wire init_wr  = reg_wr && !reg_sel;
  wire init_ok  = init_wr && (since_wr >= GAP_MAX);
  wire ctrl_wr  = reg_wr && reg_sel;
  wire running  = !stop_q && !low_power && !wake;
  wire last_one = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_wr <= GAP_MAX;
      init_q   <= RST_LOAD;
    end else if (init_ok) begin
      since_wr <= GAP_W'(1);
      init_q   <= (reg_wdata == '0) ? CNT_W'(1) : reg_wdata;
    end else if (since_wr < GAP_MAX) begin
      since_wr <= since_wr + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      soft_q <= ctrl_wr && reg_wdata[1];
      if (ctrl_wr) stop_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= RST_LOAD;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (wake) begin
        cnt_q <= init_q;
      end else if (running) begin
        if (last_one) begin
          cnt_q    <= init_q;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign init_value = init_q;
  assign cur_count  = cnt_q;
  assign stop_state = stop_q;
  assign expire_rst = expire_q;
  assign soft_rst   = soft_q;

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_state && !low_power && !wake && cur_count > CNT_W'(1)) |=> cur_count == $past(cur_count) - CNT_W'(1));
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_state && !wake) |=> cur_count == $past(cur_count));
  p_lp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && !wake) |=> cur_count == $past(cur_count));
  p_wake_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> cur_count == $past(init_value));
  p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_state && !low_power && !wake && cur_count == CNT_W'(1)) |=> (expire_rst && cur_count == $past(init_value)));
  p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_count != '0);
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_wr && since_wr < GAP_MAX) |=> $stable(init_value));
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_ok && reg_wdata == '0) |=> init_value == CNT_W'(1));
  p_soft_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[1]) |=> soft_rst);
  p_soft_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && reg_wdata[1]) |=> !soft_rst);
endmodule

// File: tb/sleep_wdt_bench.sv
module sleep_wdt_bench;
  localparam int CLK_P = 10;
  localparam int W = 5;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_sel = 0, low_power = 0, wake = 0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] init_value, cur_count;
  logic stop_state, expire_rst, soft_rst;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sleep_wdt #(.CNT_W(W), .WR_GAP(2), .RST_INIT(5)) u_sleep_wdt (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .low_power(low_power), .wake(wake), .init_value(init_value), .cur_count(cur_count),
    .stop_state(stop_state), .expire_rst(expire_rst), .soft_rst(soft_rst));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input bit sel, input int data);
    reg_wr = 1; reg_sel = sel; reg_wdata = W'(data);
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic do_wake();
    wake = 1;
    @(negedge clk);
    wake = 0;
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(cur_count == 5, "R1 count", cur_count, 5);
    chk(init_value == 5, "R1 init", init_value, 5);
    chk(!stop_state && !expire_rst && !soft_rst, "R1 flags", {stop_state, expire_rst, soft_rst}, 0);
    step();
    chk(cur_count == 4, "R2 first step", cur_count, 4);

    wr(0, 7);
    chk(init_value == 7, "R7 first write", init_value, 7);
    wr(0, 9);
    chk(init_value == 7, "R7 early write dropped", init_value, 7);
    wr(0, 9);
    chk(init_value == 9, "R7 write on limit", init_value, 9);
    step(); step();
    wr(0, 0);
    chk(init_value == 1, "R8 zero becomes one", init_value, 1);

    for (int v = 1; v < 32; v++) begin
      step(); step(); step();
      wr(0, v);
      chk(init_value == W'(v), "R7 sweep write", init_value, v);
      do_wake();
      chk(cur_count == W'(v), "R5 wake reload", cur_count, v);
      for (int n = 1; n <= v; n++) begin
        step();
        if (n < v) begin
          chk(!expire_rst, "R6 no early expiry", expire_rst, 0);
          chk(cur_count == W'(v - n), "R2 count step", cur_count, v - n);
        end else begin
          chk(expire_rst, "R6 expiry on time", expire_rst, 1);
          chk(cur_count == W'(v), "R6 reload", cur_count, v);
        end
      end
      step();
      if (v > 1) begin
        chk(!expire_rst, "R6 one-cycle pulse", expire_rst, 0);
        chk(cur_count == W'(v - 1), "R2 after reload", cur_count, v - 1);
      end
    end

    step(); step(); step();
    wr(0, 20);
    do_wake();
    wr(1, 1);
    chk(stop_state, "R3 stop set", stop_state, 1);
    c = cur_count;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(cur_count == W'(c), "R3 held", cur_count, c);
    end
    wr(1, 0);
    chk(cur_count == W'(c), "R3 held on clear", cur_count, c);
    step();
    chk(cur_count == W'(c - 1), "R3 resume", cur_count, c - 1);

    c = cur_count;
    low_power = 1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(cur_count == W'(c), "R4 low power hold", cur_count, c);
    end
    do_wake();
    chk(cur_count == 20, "R5 wake during low power", cur_count, 20);
    step();
    chk(cur_count == 20, "R4 hold after wake", cur_count, 20);
    low_power = 0;
    step();
    chk(cur_count == 19, "R4 resume", cur_count, 19);

    wr(1, 2);
    chk(soft_rst && !stop_state, "R9 soft pulse", {soft_rst, stop_state}, 2);
    step();
    chk(!soft_rst, "R9 pulse ends", soft_rst, 0);
    wr(1, 0);
    chk(!soft_rst, "R9 zero no effect", soft_rst, 0);
    wr(1, 3);
    chk(soft_rst && stop_state, "R9 soft with stop", {soft_rst, stop_state}, 3);
    step();
    chk(!soft_rst, "R9 pulse ends again", soft_rst, 0);
    wr(1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule